// File: doc/BRIEF.md
# TDM Slot Transmitter

This block is the transmit half of a time-division-multiplexed serial port. Up to three serial lanes share one bit-rate strobe, one frame marker and one slot counter. A lane pairs a parallel holding register with a shift register. When a slot opens, each enabled lane copies its holding register into the shift register, formatted for the selected word length, alignment and bit order. The word is then sent one bit per bit-enable strobe while the lane's output-enable is high.

A separate timing generator supplies the `slotStart`, `frameSync` and `bitEn` strobes. Software-side logic writes the holding registers, a 32-bit per-slot mask and a null-slot register through a simple write port. The block reports three things: a "service needed" flag, an underrun flag and a one-cycle pulse when the final slot of a multi-slot frame begins. Masked slots and null slots leave every lane in high impedance, and masked slots do not disturb either flag.

Top module: `tdm_slot_tx`

## Requirements
- R1: During and after reset, before any slot opens, every `serOe` bit, `underrunFlag` and `lastSlotIrq` are 0 and `emptyFlag` is 1. The reset slot mask enables all 32 slots.
- R2: A write with `wrAddr` = 0, 1 or 2 loads `wrData[23:0]` into the holding register of that lane. `wrAddr` = 3 loads the 32-bit slot mask, and `wrAddr` = 4 is the null-slot register, whose data is discarded.
- R3: `cfgWordLen` selects the word size: 0 = 8 bits, 1 = 12, 2 = 16, 3 = 24, 4 = 32 with the valid bits leading, 5 = 32 with the valid bits trailing. Codes 6 and 7 act as 24. After a slot opens, an enabled lane drives for exactly that many bit periods and is then in high impedance until the next slot.
- R4: For 8, 12 and 16-bit words, the word is taken from the top of the holding register (ending at bit 23) when `cfgAlign15` = 0, and ending at bit 15 when it is 1. For 24 and 32-bit words, `cfgAlign15` has no effect.
- R5: With `cfgLsbFirst` = 0 the most significant bit of the word goes first; with 1 the least significant goes first.
- R6: Code 4 sends the 24 valid bits, then repeats the last one sent 8 times. Code 5 sends the first valid bit 8 times, then all 24 valid bits.
- R7: The first bit appears on `serOut` in the cycle after the clock edge that samples `slotStart`. Each sampled `bitEn` moves to the next bit one cycle later.
- R8: `emptyFlag` sets when an open slot transfers the holding registers. It clears only once every enabled lane has been written since that transfer, or when the null-slot register is written.
- R9: When an open slot begins while any enabled lane has no new data, `underrunFlag` sets, and that lane resends the word it last held.
- R10: `underrunFlag` clears only when a `statusRd` pulse seen while it is set is followed by a holding-register or null-slot write. A write without that prior read leaves it set.
- R11: With `cfgNetwork` = 1, slots are numbered 0 to `cfgSlotsM1`. `frameSync` together with `slotStart` restarts numbering at 0. Slot n with mask bit n clear keeps every lane in high impedance, transfers nothing and changes neither flag. With `cfgNetwork` = 0 the mask is ignored.
- R12: After a null-slot write, the next slot that the mask leaves open keeps every lane in high impedance and raises no underrun. The holding registers are not consumed.
- R13: Lanes 1 and 2 take part (drive, and count toward the empty condition) only when `cfgSync` = 1. `lane0Active` equals `serOe[0]`.
- R14: With `cfgNetwork` = 1, `lastSlotIrq` is high for one cycle right after the `slotStart` that opens slot `cfgSlotsM1`. It never fires with `cfgNetwork` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordLen | input | 3 | Word length code |
| cfgAlign15 | input | 1 | Short words end at bit 15 instead of 23 |
| cfgLsbFirst | input | 1 | Bit order select |
| cfgNetwork | input | 1 | Multi-slot frames with mask |
| cfgSync | input | 1 | Shared-clock mode; permits lanes 1 and 2 |
| cfgSlotsM1 | input | 5 | Slots per frame minus one |
| cfgLaneEn | input | 3 | Lane enables |
| slotStart | input | 1 | Slot boundary strobe |
| frameSync | input | 1 | Marks the slot opened by slotStart as slot 0 |
| bitEn | input | 1 | Bit advance strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| statusRd | input | 1 | Status read pulse (arms underrun clear) |
| serOut | output | 3 | Serial data, one per lane |
| serOe | output | 3 | Output enable per lane (0 = high impedance) |
| lane0Active | output | 1 | External buffer enable for lane 0 |
| emptyFlag | output | 1 | Holding registers need service |
| underrunFlag | output | 1 | Slot opened with stale data |
| lastSlotIrq | output | 1 | Final slot of frame has begun |

## Verification
The hardest case is a masked slot placed between two open slots. At that point all holding registers must be full and the underrun flag must be clear, otherwise silence on the flags proves nothing. The bench therefore refills every lane and clears any underrun just before the masked slot. It then counts through a four-slot frame until the last slot opens without new data. That last slot checks the slot numbering, the final-slot pulse and the resend of the old word together. A complete sweep of word-length code, alignment and bit order sits alongside this, with every bit compared against a position computed arithmetically.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int DATA_W    = 24;
  localparam int SEQ_W     = 32;
  localparam int ADDR_W    = 3;
  localparam int ADDR_MASK = 3;
  localparam int ADDR_NULL = 4;

  typedef struct packed {
    logic slotBegin;
    logic loadWords;
    logic txOn;
  } txStrobes_t;

  function automatic logic [5:0] wordBits(input logic [2:0] code);
    case (code)
      3'd0: wordBits = 6'd8;
      3'd1: wordBits = 6'd12;
      3'd2: wordBits = 6'd16;
      3'd4, 3'd5: wordBits = 6'd32;
      default: wordBits = 6'd24;
    endcase
  endfunction

  function automatic logic [SEQ_W-1:0] buildSeq(input logic [DATA_W-1:0] din,
                                                input logic [2:0] code,
                                                input logic align15,
                                                input logic lsbFirst);
    int n;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] ordered;
    logic [SEQ_W-1:0] seq;
    n = int'(wordBits(code));
    if (n > DATA_W) n = DATA_W;
    field = din;
    if (n < DATA_W) begin
      field = align15 ? (din >> (16 - n)) : (din >> (DATA_W - n));
      field = field & ~({DATA_W{1'b1}} << n);
    end
    ordered = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) ordered[i] = lsbFirst ? field[i] : field[n-1-i];
    end
    seq = '0;
    for (int i = 0; i < SEQ_W; i++) begin
      if (code == 3'd4)      seq[i] = ordered[(i < DATA_W) ? i : DATA_W-1];
      else if (code == 3'd5) seq[i] = ordered[(i < 8) ? 0 : i-8];
      else if (i < DATA_W)   seq[i] = ordered[(i < DATA_W) ? i : 0];
    end
    return seq;
  endfunction
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int SLOT_CNT  = 32,
  parameter int WR_W      = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgNetwork,
  input  logic                        cfgSync,
  input  logic [$clog2(SLOT_CNT)-1:0] cfgSlotsM1,
  input  logic [NUM_LANES-1:0]        cfgLaneEn,
  input  logic                        slotStart,
  input  logic                        frameSync,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [WR_W-1:0]             wrData,
  input  logic                        statusRd,
  output txStrobes_t                  strb,
  output logic [NUM_LANES-1:0]        laneActive,
  output logic                        emptyFlag,
  output logic                        underrunFlag,
  output logic                        lastSlotIrq
);
  localparam int SLOT_W = $clog2(SLOT_CNT);

  logic [SLOT_W-1:0]    slotCnt, nextSlot;
  logic [SLOT_CNT-1:0]  slotMask;
  logic [NUM_LANES-1:0] fresh, dataWr, freshAfterWr;
  logic                 nullPend, rdArmed, txOnQ;
  logic                 nullWr, maskWr, slotOpen, beginLive, beginNull, allFilled;

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      laneActive[l] = cfgLaneEn[l] & ((l == 0) | cfgSync);
      dataWr[l]     = wrEn && (wrAddr == ADDR_W'(l));
    end
    nullWr       = wrEn && (wrAddr == ADDR_W'(ADDR_NULL));
    maskWr       = wrEn && (wrAddr == ADDR_W'(ADDR_MASK));
    if (!cfgNetwork || frameSync || slotCnt == cfgSlotsM1) nextSlot = '0;
    else nextSlot = slotCnt + 1'b1;
    slotOpen     = !cfgNetwork || slotMask[nextSlot];
    beginLive    = slotStart && slotOpen && !nullPend;
    beginNull    = slotStart && slotOpen && nullPend;
    freshAfterWr = fresh | dataWr;
    allFilled    = ((freshAfterWr & laneActive) == laneActive);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt      <= '0;
      slotMask     <= '1;
      fresh        <= '0;
      nullPend     <= 1'b0;
      rdArmed      <= 1'b0;
      txOnQ        <= 1'b0;
      emptyFlag    <= 1'b1;
      underrunFlag <= 1'b0;
      lastSlotIrq  <= 1'b0;
    end else begin
      if (maskWr) slotMask <= wrData[SLOT_CNT-1:0];
      if (slotStart) begin
        slotCnt <= nextSlot;
        txOnQ   <= beginLive;
      end
      lastSlotIrq <= slotStart && cfgNetwork && (nextSlot == cfgSlotsM1);

      if (beginLive) fresh <= dataWr;
      else           fresh <= freshAfterWr;

      if (beginNull)   nullPend <= nullWr;
      else if (nullWr) nullPend <= 1'b1;

      if (beginLive)                         emptyFlag <= 1'b1;
      else if (beginNull)                    emptyFlag <= !allFilled;
      else if (nullWr || (|dataWr && allFilled)) emptyFlag <= 1'b0;

      if (beginLive && |(laneActive & ~fresh)) begin
        underrunFlag <= 1'b1;
        rdArmed      <= 1'b0;
      end else if (rdArmed && (|dataWr || nullWr)) begin
        underrunFlag <= 1'b0;
        rdArmed      <= 1'b0;
      end else if (statusRd && underrunFlag) begin
        rdArmed <= 1'b1;
      end
    end
  end

  assign strb.slotBegin = slotStart;
  assign strb.loadWords = beginLive;
  assign strb.txOn      = txOnQ;

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrunFlag) |-> $past(slotStart));
  // R8
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(emptyFlag) |-> $past(wrEn));
  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStart && cfgNetwork && !slotMask[nextSlot] && !underrunFlag |=> !txOnQ && !underrunFlag);
  // R12
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStart && nullPend |=> !txOnQ);
  // R14
  last_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastSlotIrq |-> $past(slotStart) && $past(cfgNetwork));
endmodule

// File: rtl/tdm_tx_lanes.sv
module tdm_tx_lanes
  import tdm_tx_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int LANE_W    = DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strb,
  input  logic [NUM_LANES-1:0] laneActive,
  input  logic [2:0]           cfgWordLen,
  input  logic                 cfgAlign15,
  input  logic                 cfgLsbFirst,
  input  logic                 bitEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [LANE_W-1:0]    wrData,
  output logic [NUM_LANES-1:0] serOut,
  output logic [NUM_LANES-1:0] serOe
);
  localparam int CNT_W = $clog2(SEQ_W + 1);

  logic [CNT_W-1:0] bitCnt;
  logic [5:0]       wordLen;

  assign wordLen = wordBits(cfgWordLen);

  always_ff @(posedge clk) begin
    if (!rstN) bitCnt <= '0;
    else if (strb.slotBegin) bitCnt <= '0;
    else if (bitEn && bitCnt != CNT_W'(SEQ_W)) bitCnt <= bitCnt + 1'b1;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] holdReg;
    logic [SEQ_W-1:0]  seqReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdReg <= '0;
        seqReg  <= '0;
      end else begin
        if (wrEn && wrAddr == ADDR_W'(l)) holdReg <= wrData;
        if (strb.loadWords) seqReg <= buildSeq(holdReg, cfgWordLen, cfgAlign15, cfgLsbFirst);
        else if (bitEn && !strb.slotBegin) seqReg <= seqReg >> 1;
      end
    end

    assign serOe[l]  = strb.txOn && laneActive[l] && (6'(bitCnt) < wordLen);
    assign serOut[l] = serOe[l] & seqReg[0];

    // R7
    drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(serOe[l]) && $stable(laneActive) && $stable(cfgWordLen) |-> $past(strb.slotBegin));
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int SLOT_CNT  = 32,
  parameter int WR_W      = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2:0]                  cfgWordLen,
  input  logic                        cfgAlign15,
  input  logic                        cfgLsbFirst,
  input  logic                        cfgNetwork,
  input  logic                        cfgSync,
  input  logic [$clog2(SLOT_CNT)-1:0] cfgSlotsM1,
  input  logic [NUM_LANES-1:0]        cfgLaneEn,
  input  logic                        slotStart,
  input  logic                        frameSync,
  input  logic                        bitEn,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [WR_W-1:0]             wrData,
  input  logic                        statusRd,
  output logic [NUM_LANES-1:0]        serOut,
  output logic [NUM_LANES-1:0]        serOe,
  output logic                        lane0Active,
  output logic                        emptyFlag,
  output logic                        underrunFlag,
  output logic                        lastSlotIrq
);
  txStrobes_t           strb;
  logic [NUM_LANES-1:0] laneActive;

  tdm_tx_ctrl #(.NUM_LANES(NUM_LANES), .SLOT_CNT(SLOT_CNT), .WR_W(WR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgNetwork(cfgNetwork), .cfgSync(cfgSync),
    .cfgSlotsM1(cfgSlotsM1), .cfgLaneEn(cfgLaneEn), .slotStart(slotStart),
    .frameSync(frameSync), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusRd(statusRd), .strb(strb), .laneActive(laneActive),
    .emptyFlag(emptyFlag), .underrunFlag(underrunFlag), .lastSlotIrq(lastSlotIrq)
  );

  tdm_tx_lanes #(.NUM_LANES(NUM_LANES), .LANE_W(DATA_W)) u_lanes (
    .clk(clk), .rstN(rstN), .strb(strb), .laneActive(laneActive),
    .cfgWordLen(cfgWordLen), .cfgAlign15(cfgAlign15), .cfgLsbFirst(cfgLsbFirst),
    .bitEn(bitEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData[DATA_W-1:0]),
    .serOut(serOut), .serOe(serOe)
  );

  assign lane0Active = serOe[0];
endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;
  logic clk = 1'b0;
  logic rstN;
  logic [2:0] cfgWordLen;
  logic cfgAlign15, cfgLsbFirst, cfgNetwork, cfgSync;
  logic [4:0] cfgSlotsM1;
  logic [2:0] cfgLaneEn;
  logic slotStart, frameSync, bitEn, wrEn, statusRd;
  logic [2:0] wrAddr;
  logic [31:0] wrData;
  logic [2:0] serOut, serOe;
  logic lane0Active, emptyFlag, underrunFlag, lastSlotIrq;

  int checks = 0;
  int fails = 0;
  logic [33:0] cap [3];
  int oeCnt [3];
  int l0Bad = 0;
  logic irqSeen;

  always #2 clk = ~clk;

  tdm_slot_tx u0 (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgAlign15(cfgAlign15),
    .cfgLsbFirst(cfgLsbFirst), .cfgNetwork(cfgNetwork), .cfgSync(cfgSync),
    .cfgSlotsM1(cfgSlotsM1), .cfgLaneEn(cfgLaneEn), .slotStart(slotStart),
    .frameSync(frameSync), .bitEn(bitEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statusRd(statusRd), .serOut(serOut), .serOe(serOe),
    .lane0Active(lane0Active), .emptyFlag(emptyFlag), .underrunFlag(underrunFlag),
    .lastSlotIrq(lastSlotIrq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrAddr = 3'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdStatus();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic runSlot(input bit fs);
    for (int l = 0; l < 3; l++) begin oeCnt[l] = 0; cap[l] = '0; end
    slotStart = 1'b1; frameSync = fs;
    @(negedge clk);
    slotStart = 1'b0; frameSync = 1'b0;
    irqSeen = lastSlotIrq;
    for (int i = 0; i < 34; i++) begin
      for (int l = 0; l < 3; l++) begin
        cap[l][i] = serOut[l];
        if (serOe[l]) oeCnt[l]++;
      end
      if (lane0Active !== serOe[0]) l0Bad++;
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
    end
  endtask

  function automatic int lenOf(input int wl);
    if (wl == 0) return 8;
    if (wl == 1) return 12;
    if (wl == 2) return 16;
    if (wl == 4 || wl == 5) return 32;
    return 24;
  endfunction

  function automatic logic expBit(input logic [23:0] d, input int wl, input int al,
                                  input int lsb, input int i);
    int n, j, top, bot, pos;
    n = (lenOf(wl) == 32) ? 24 : lenOf(wl);
    if (wl == 4) j = (i < 24) ? i : 23;
    else if (wl == 5) j = (i < 8) ? 0 : i - 8;
    else j = i;
    top = (n < 24 && al != 0) ? 15 : 23;
    bot = top - n + 1;
    pos = (lsb != 0) ? bot + j : top - j;
    return d[pos];
  endfunction

  function automatic logic [31:0] expWord(input logic [23:0] d, input int wl,
                                          input int al, input int lsb);
    logic [31:0] w = '0;
    for (int i = 0; i < lenOf(wl); i++) w[i] = expBit(d, wl, al, lsb, i);
    return w;
  endfunction

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] pats [2];
    logic [23:0] d0, d1, d2;
    logic [31:0] got, exp;
    pats[0] = 24'hC3A596; pats[1] = 24'h1E7F08;
    d0 = 24'hA1B2C3; d1 = 24'h5D6E7F; d2 = 24'h0F1E2D;
    rstN = 1'b0; cfgWordLen = 3'd3; cfgAlign15 = 0; cfgLsbFirst = 0; cfgNetwork = 0;
    cfgSync = 1; cfgSlotsM1 = 0; cfgLaneEn = 3'b001; slotStart = 0; frameSync = 0;
    bitEn = 0; wrEn = 0; wrAddr = 0; wrData = 0; statusRd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(serOe == 3'b000, "R1", "serOe", serOe, 0);
    chk(emptyFlag == 1'b1, "R1", "emptyFlag", emptyFlag, 1);
    chk(underrunFlag == 1'b0 && lastSlotIrq == 1'b0, "R1", "underrun/irq",
        {underrunFlag, lastSlotIrq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset mask opens every slot
    cfgNetwork = 1; cfgSlotsM1 = 5'd1;
    wr(0, {8'h0, d0});
    runSlot(1);
    chk(oeCnt[0] == 24, "R1", "open slot after reset", oeCnt[0], 24);
    cfgNetwork = 0; cfgSlotsM1 = 0;

    // R3 R4 R5 R6 R7 sweep on lane 0
    for (int wl = 0; wl < 8; wl++)
      for (int al = 0; al < 2; al++)
        for (int lsb = 0; lsb < 2; lsb++)
          for (int p = 0; p < 2; p++) begin
            cfgWordLen = 3'(wl); cfgAlign15 = al[0]; cfgLsbFirst = lsb[0];
            wr(0, {8'h0, pats[p]});
            runSlot(0);
            exp = expWord(pats[p], wl, al, lsb);
            got = '0;
            for (int i = 0; i < lenOf(wl); i++) got[i] = cap[0][i];
            chk(got == exp, "R3 R4 R5 R6 R7", "bit stream", got, exp);
            chk(oeCnt[0] == lenOf(wl), "R3", "drive length", oeCnt[0], lenOf(wl));
            chk(emptyFlag == 1'b1 && underrunFlag == 1'b0, "R8", "flags after slot",
                {emptyFlag, underrunFlag}, 2);
          end

    // R8 empty needs every enabled lane; R2 lane addressing
    cfgWordLen = 3'd3; cfgAlign15 = 0; cfgLsbFirst = 0; cfgLaneEn = 3'b111;
    wr(0, {8'h0, d0});
    chk(emptyFlag == 1'b1, "R8", "after lane0 write", emptyFlag, 1);
    wr(1, {8'h0, d1});
    chk(emptyFlag == 1'b1, "R8", "after lane1 write", emptyFlag, 1);
    wr(2, {8'h0, d2});
    chk(emptyFlag == 1'b0, "R8", "after lane2 write", emptyFlag, 0);
    runSlot(0);
    chk(cap[0][23:0] == expWord(d0, 3, 0, 0), "R2", "lane0 word", cap[0][23:0], expWord(d0, 3, 0, 0));
    chk(cap[1][23:0] == expWord(d1, 3, 0, 0), "R2", "lane1 word", cap[1][23:0], expWord(d1, 3, 0, 0));
    chk(cap[2][23:0] == expWord(d2, 3, 0, 0), "R2", "lane2 word", cap[2][23:0], expWord(d2, 3, 0, 0));
    chk(underrunFlag == 1'b0, "R9", "no underrun when filled", underrunFlag, 0);

    // R9 underrun and resend
    runSlot(0);
    chk(underrunFlag == 1'b1, "R9", "underrun set", underrunFlag, 1);
    chk(cap[1][23:0] == expWord(d1, 3, 0, 0) && oeCnt[1] == 24, "R9", "lane1 resend",
        cap[1][23:0], expWord(d1, 3, 0, 0));

    // R10 clear sequence
    wr(0, {8'h0, d0});
    chk(underrunFlag == 1'b1, "R10", "write without read", underrunFlag, 1);
    rdStatus();
    chk(underrunFlag == 1'b1, "R10", "read alone", underrunFlag, 1);
    wr(1, {8'h0, d1});
    chk(underrunFlag == 1'b0, "R10", "read then write", underrunFlag, 0);
    wr(2, {8'h0, d2});

    // R11 R14 network frame of four slots, slot 1 masked
    cfgNetwork = 1; cfgSlotsM1 = 5'd3;
    wr(3, 32'hFFFF_FFFD);
    runSlot(1);
    chk(oeCnt[0] == 24 && oeCnt[2] == 24, "R11", "slot0 drives", oeCnt[0], 24);
    chk(irqSeen == 1'b0, "R14", "slot0 irq", irqSeen, 0);
    wr(0, {8'h0, d2}); wr(1, {8'h0, d0}); wr(2, {8'h0, d1});
    chk(emptyFlag == 1'b0, "R8", "refilled", emptyFlag, 0);
    runSlot(0);
    chk(oeCnt[0] + oeCnt[1] + oeCnt[2] == 0, "R11", "masked slot silent",
        oeCnt[0] + oeCnt[1] + oeCnt[2], 0);
    chk(emptyFlag == 1'b0 && underrunFlag == 1'b0, "R11", "masked slot flags",
        {emptyFlag, underrunFlag}, 0);
    runSlot(0);
    chk(cap[0][23:0] == expWord(d2, 3, 0, 0), "R11", "slot2 word", cap[0][23:0], expWord(d2, 3, 0, 0));
    chk(emptyFlag == 1'b1 && underrunFlag == 1'b0, "R11", "slot2 flags",
        {emptyFlag, underrunFlag}, 2);
    chk(irqSeen == 1'b0, "R14", "slot2 irq", irqSeen, 0);
    runSlot(0);
    chk(irqSeen == 1'b1, "R14", "last slot irq", irqSeen, 1);
    chk(underrunFlag == 1'b1, "R11", "slot3 underrun", underrunFlag, 1);
    chk(lastSlotIrq == 1'b0, "R14", "irq one cycle", lastSlotIrq, 0);
    rdStatus();
    wr(0, {8'h0, d0}); wr(1, {8'h0, d1}); wr(2, {8'h0, d2});

    // R11 normal mode ignores mask; R14 no irq
    cfgNetwork = 0; cfgSlotsM1 = 0;
    wr(3, 32'hFFFF_FFFE);
    runSlot(0);
    chk(oeCnt[0] == 24 && oeCnt[1] == 24, "R11", "normal ignores mask", oeCnt[0], 24);
    chk(irqSeen == 1'b0, "R14", "normal mode irq", irqSeen, 0);

    // R12 null slot
    wr(4, 32'h0);
    chk(emptyFlag == 1'b0, "R12", "null write services empty", emptyFlag, 0);
    runSlot(0);
    chk(oeCnt[0] + oeCnt[1] + oeCnt[2] == 0, "R12", "null slot silent",
        oeCnt[0] + oeCnt[1] + oeCnt[2], 0);
    chk(underrunFlag == 1'b0, "R12", "null slot no underrun", underrunFlag, 0);
    runSlot(0);
    chk(oeCnt[0] == 24 && underrunFlag == 1'b1, "R12", "null consumed once",
        {oeCnt[0], underrunFlag}, {24, 1'b1});

    // R13 asynchronous mode keeps lanes 1 and 2 out
    rdStatus();
    cfgSync = 0;
    wr(0, {8'h0, d1});
    chk(underrunFlag == 1'b0, "R10", "cleared", underrunFlag, 0);
    chk(emptyFlag == 1'b0, "R13", "lane0 alone fills", emptyFlag, 0);
    runSlot(0);
    chk(oeCnt[0] == 24 && oeCnt[1] == 0 && oeCnt[2] == 0, "R13", "lane drive",
        {oeCnt[0], oeCnt[1], oeCnt[2]}, 24);
    chk(cap[0][23:0] == expWord(d1, 3, 0, 0), "R13", "lane0 word", cap[0][23:0], expWord(d1, 3, 0, 0));
    chk(l0Bad == 0, "R13", "lane0Active mismatches", l0Bad, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule